// File: doc/BRIEF.md
# Core Tick Timer

This block is the per-core tick timer. It holds a 32-bit count that moves forward on every core clock, and a control word. The control word selects how the count behaves when it reaches a programmed point, gates an interrupt, and keeps a sticky pending flag. A match happens when the low 28 bits of the count equal the 28-bit period held in the control word. The timer then sets the pending flag. When the interrupt enable is also set, the interrupt line goes high.

Software uses one strobe-and-select port to reach both words. It can load a new count at any time. It can re-arm a one-shot event without stopping the count: read the count, add a delta, keep the low 28 bits, and write that result as the new period with continuous mode and the interrupt enabled. To acknowledge the interrupt, software writes a control word that has only the mode bits set. That write clears the pending flag and the enable, and the count keeps running. A constant output tells the core that the timer is fitted.

Top module: `tick_timer`

## Requirements
- R1: After a synchronous reset the count reads 0, the control word reads 0 (mode disabled), `irq` is 0 and `present` is 1.
- R2: The control word is laid out as follows. Bits 31:30 hold the mode: 00 disabled, 01 restart, 10 stop, 11 continuous. Bit 29 is the interrupt enable, bit 28 is the pending flag and bits 27:0 are the period. Reading the control word returns the value last written, except for the pending bit.
- R3: In any mode other than disabled, the count goes up by one on each clock. In disabled mode it holds its value.
- R4: In continuous mode the count runs on through a match without any change, and it wraps from 32'hFFFF_FFFF to 0.
- R5: The match compares only count bits 27:0 with the period. The pending flag reads 1 from the cycle after the cycle in which the count shows the matching value.
- R6: In restart mode the count reads 0 in the cycle after the match.
- R7: In stop mode the count holds the matching value until the control word is rewritten with another mode. After that write it resumes counting without raising pending again.
- R8: `irq` is high exactly when both the enable bit and the pending flag are 1.
- R9: A control write with bit 28 at 0 clears pending. A control write with bit 28 at 1 keeps pending but never sets it. A control write does not disturb the count.
- R10: A count write (select 0) loads `wdata` at the next edge and takes priority over that cycle's increment.
- R11: A match in the same cycle as a control write that clears pending still leaves pending set.
- R12: While the count is held in stop mode, a cleared pending flag is not set again by the ongoing match.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the selected word |
| reg_sel | input | 1 | 0 selects the count, 1 selects the control word (both read and write) |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Selected word, combinational on `reg_sel` |
| irq | output | 1 | Timer interrupt request |
| present | output | 1 | Constant 1: timer fitted |

## Verification
A write presented before a rising edge shows in `rdata` right after that edge. A match seen in the count during one cycle shows as pending, and through the gate on `irq`, one edge later. A restart or a stop-hold acts on the edge that follows the matching cycle. The bench drives inputs just after the falling edge and compares all outputs at the falling edge against a behavioural model that is advanced on each rising edge. Targeted checks read values a whole number of cycles after each write, and the cycle counts are worked out by hand from these delays.

// File: rtl/tick_pkg.sv
package tick_pkg;

    localparam int CNT_W = 32;
    localparam int PER_W = 28;

    typedef enum logic [1:0] {
        TM_OFF     = 2'b00,
        TM_RESTART = 2'b01,
        TM_STOP    = 2'b10,
        TM_CONT    = 2'b11
    } tmode_e;

    typedef struct packed {
        tmode_e             mode;
        logic               ie;
        logic               pend;
        logic [PER_W-1:0]   period;
    } tctl_t;

    function automatic logic low_match(
        input logic [CNT_W-1:0] c,
        input logic [PER_W-1:0] p
    );
        return c[PER_W-1:0] == p;
    endfunction

endpackage

// File: rtl/tick_match.sv
module tick_match
    import tick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PER_W
) (
    input  logic [CW-1:0] cnt,
    input  tmode_e        mode,
    input  logic [PW-1:0] period,
    input  logic          held,
    output logic          match,
    output logic          hit
);
    always_comb begin
        match = low_match(cnt, period);
        hit   = match && (mode != TM_OFF) && !held;
    end
endmodule

// File: rtl/tick_counter.sv
module tick_counter
    import tick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  tmode_e        mode,
    input  logic          match,
    output logic [CW-1:0] cnt
);
    logic [CW-1:0] cnt_n;

    always_comb begin
        cnt_n = cnt;
        if (wr) begin
            cnt_n = wdata;
        end else begin
            unique case (mode)
                TM_OFF:     cnt_n = cnt;
                TM_RESTART: cnt_n = match ? '0 : cnt + 1'b1;
                TM_STOP:    cnt_n = match ? cnt : cnt + 1'b1;
                TM_CONT:    cnt_n = cnt + 1'b1;
                default:    cnt_n = cnt;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) cnt <= '0;
        else     cnt <= cnt_n;
    end

    AST_STEP: assert property (@(posedge clk) disable iff (rst)
        (!wr && mode != TM_OFF && !match) |=> cnt == $past(cnt) + 1'b1); // R3
    AST_FREEZE: assert property (@(posedge clk) disable iff (rst)
        (!wr && mode == TM_OFF) |=> $stable(cnt)); // R3
    AST_LOAD: assert property (@(posedge clk) disable iff (rst)
        wr |=> cnt == $past(wdata)); // R10
    AST_RESTART: assert property (@(posedge clk) disable iff (rst)
        (!wr && mode == TM_RESTART && match) |=> cnt == '0); // R6
    AST_HOLD: assert property (@(posedge clk) disable iff (rst)
        (!wr && mode == TM_STOP && match) |=> $stable(cnt)); // R7
endmodule

// File: rtl/tick_ctrl.sv
module tick_ctrl
    import tick_pkg::*;
#(
    parameter int CW = CNT_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr,
    input  logic [CW-1:0] wdata,
    input  logic          match,
    input  logic          hit,
    output tctl_t         ctl,
    output logic          held
);
    tctl_t wr_word;
    tctl_t ctl_n;

    always_comb begin
        wr_word = tctl_t'(wdata);
        ctl_n   = ctl;
        if (wr) begin
            ctl_n      = wr_word;
            ctl_n.pend = hit | (wr_word.pend & ctl.pend);
        end else begin
            ctl_n.pend = hit | ctl.pend;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctl  <= '0;
            held <= 1'b0;
        end else begin
            ctl  <= ctl_n;
            held <= (ctl.mode == TM_STOP) && match;
        end
    end

    AST_HIT_SETS: assert property (@(posedge clk) disable iff (rst)
        hit |=> ctl.pend); // R11
    AST_NO_SELF_SET: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pend && !hit) |=> !ctl.pend); // R9
    AST_ACK_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (wr && !wdata[28] && !hit) |=> !ctl.pend); // R9
    AST_HELD_QUIET: assert property (@(posedge clk) disable iff (rst)
        (held && !ctl.pend && !wr && ctl.mode == TM_STOP) |=> !ctl.pend); // R12
endmodule

// File: rtl/tick_timer.sv
module tick_timer
    import tick_pkg::*;
#(
    parameter int CW = CNT_W,
    parameter int PW = PER_W
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          wr_en,
    input  logic          reg_sel,
    input  logic [CW-1:0] wdata,
    output logic [CW-1:0] rdata,
    output logic          irq,
    output logic          present
);
    localparam logic SEL_CNT = 1'b0;
    localparam logic SEL_CTL = 1'b1;

    logic [CW-1:0] cnt;
    tctl_t         ctl;
    logic          held;
    logic          match;
    logic          hit;
    logic          cnt_wr;
    logic          ctl_wr;

    assign cnt_wr = wr_en && (reg_sel == SEL_CNT);
    assign ctl_wr = wr_en && (reg_sel == SEL_CTL);

    tick_match #(.CW(CW), .PW(PW)) u_match (
        .cnt    (cnt),
        .mode   (ctl.mode),
        .period (ctl.period),
        .held   (held),
        .match  (match),
        .hit    (hit)
    );

    tick_counter #(.CW(CW)) u_cnt (
        .clk   (clk),
        .rst   (rst),
        .wr    (cnt_wr),
        .wdata (wdata),
        .mode  (ctl.mode),
        .match (match),
        .cnt   (cnt)
    );

    tick_ctrl #(.CW(CW)) u_ctl (
        .clk   (clk),
        .rst   (rst),
        .wr    (ctl_wr),
        .wdata (wdata),
        .match (match),
        .hit   (hit),
        .ctl   (ctl),
        .held  (held)
    );

    assign rdata   = (reg_sel == SEL_CTL) ? CW'(ctl) : cnt;
    assign irq     = ctl.ie & ctl.pend;
    assign present = 1'b1;

    AST_IRQ_NEEDS_PEND: assert property (@(posedge clk) disable iff (rst)
        (!ctl.pend && !hit) |=> !irq); // R8
endmodule

// File: tb/tick_timer_test.sv
module tick_timer_test;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        reg_sel = 1'b0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;
    logic        irq;
    logic        present;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    always #4 clk = ~clk;

    tick_timer uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .reg_sel(reg_sel),
        .wdata(wdata), .rdata(rdata), .irq(irq), .present(present)
    );

    // behavioural reference
    logic [31:0] m_cnt;
    logic [1:0]  m_mode;
    bit          m_ie, m_pend, m_held;
    logic [27:0] m_per;

    always @(posedge clk) begin
        bit is_match, is_hit;
        logic [31:0] nc;
        if (rst) begin
            m_cnt = 0; m_mode = 0; m_ie = 0; m_pend = 0; m_held = 0; m_per = 0;
        end else begin
            is_match = (m_cnt % 32'h1000_0000) == {4'h0, m_per};
            is_hit = is_match && (m_mode != 0) && !m_held;
            nc = m_cnt;
            if (wr_en && !reg_sel) nc = wdata;
            else if (m_mode == 1) nc = is_match ? 0 : m_cnt + 1;
            else if (m_mode == 2) nc = is_match ? m_cnt : m_cnt + 1;
            else if (m_mode == 3) nc = m_cnt + 1;
            m_held = (m_mode == 2) && is_match;
            if (wr_en && reg_sel) begin
                m_pend = is_hit || (wdata[28] && m_pend);
                m_mode = wdata[31:30]; m_ie = wdata[29]; m_per = wdata[27:0];
            end else begin
                m_pend = is_hit || m_pend;
            end
            m_cnt = nc;
        end
    end

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!rst && !done) begin
            chk({cur_req, " model rdata"}, rdata,
                reg_sel ? {m_mode, m_ie, m_pend, m_per} : m_cnt);
            chk({cur_req, " model irq"}, {31'd0, irq}, {31'd0, m_ie & m_pend});
            chk("R1 present", {31'd0, present}, 32'd1);
        end
    end

    function automatic logic [31:0] mw(input logic [1:0] m, input bit ie,
                                       input bit pd, input logic [27:0] p);
        return {m, ie, pd, p};
    endfunction

    task automatic tick(input int n);
        repeat (n) @(negedge clk);
        #1;
    endtask

    task automatic wr(input logic s, input logic [31:0] d);
        @(negedge clk); #1;
        wr_en = 1; reg_sel = s; wdata = d;
        @(negedge clk); #1;
        wr_en = 0; reg_sel = 0;
    endtask

    task automatic rd(input logic s, output logic [31:0] v);
        reg_sel = s; #1; v = rdata;
    endtask

    task automatic finish_run();
        done = 1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        logic [31:0] v, a;
        repeat (3) @(negedge clk);
        #1 rst = 0;
        // R1 reset state
        rd(0, v); chk("R1 count", v, 0);
        rd(1, v); chk("R1 ctrl", v, 0);
        chk("R1 irq", {31'd0, irq}, 0);
        reg_sel = 0;
        // R3 disabled holds
        cur_req = "R3";
        tick(4); rd(0, v); chk("R3 off holds", v, 0);
        wr(1, mw(2'b11, 0, 0, 28'h0FF_FFFF));
        rd(0, a); chk("R3 start", a, 0);
        tick(5); rd(0, v); chk("R3 step", v, a + 5);
        // R10 count write priority
        cur_req = "R10";
        wr(0, 32'd100); rd(0, v); chk("R10 load", v, 100);
        tick(1); rd(0, v); chk("R10 then count", v, 101);
        // R4 / R5 wrap and low-bit match
        cur_req = "R4";
        wr(1, mw(2'b11, 1, 0, 28'hFFF_FFFF));
        wr(0, 32'hFFFF_FFFE); rd(0, v); chk("R4 load", v, 32'hFFFF_FFFE);
        tick(1); rd(0, v); chk("R4 at match", v, 32'hFFFF_FFFF);
        rd(1, v); chk("R5 not yet pending", {31'd0, v[28]}, 0);
        tick(1); rd(0, v); chk("R4 wrap", v, 0);
        rd(1, v); chk("R5 pending", {31'd0, v[28]}, 1);
        chk("R8 irq on", {31'd0, irq}, 1);
        reg_sel = 0;
        tick(1); rd(0, v); chk("R4 runs on", v, 1);
        // R9 acknowledge
        cur_req = "R9";
        wr(1, mw(2'b11, 1, 0, 28'hFFF_FFFF));
        rd(0, v); chk("R9 count undisturbed", v, 3);
        rd(1, v); chk("R9 cleared", {31'd0, v[28]}, 0);
        chk("R9 irq off", {31'd0, irq}, 0);
        wr(1, mw(2'b11, 1, 1, 28'hFFF_FFFF));
        rd(1, v); chk("R9 no self set", {31'd0, v[28]}, 0);
        // R8 enable gating
        cur_req = "R8";
        wr(1, mw(2'b11, 0, 0, 28'd20));
        wr(0, 32'd18);
        tick(3); rd(1, v); chk("R8 pending w/o ie", {31'd0, v[28]}, 1);
        chk("R8 irq gated", {31'd0, irq}, 0);
        wr(1, mw(2'b11, 1, 1, 28'd20));
        rd(1, v); chk("R2 readback", v, mw(2'b11, 1, 1, 28'd20));
        chk("R8 irq both", {31'd0, irq}, 1);
        // R11 match with clearing write
        cur_req = "R11";
        wr(1, mw(2'b11, 1, 0, 28'd40));
        wr(0, 32'd38);
        tick(1);
        wr(1, mw(2'b11, 1, 0, 28'd40));
        rd(1, v); chk("R11 hit wins", {31'd0, v[28]}, 1);
        rd(0, v); chk("R11 count", v, 41);
        // R6 restart
        cur_req = "R6";
        wr(1, mw(2'b01, 0, 0, 28'd5));
        wr(0, 32'd3);
        tick(2); rd(0, v); chk("R6 at period", v, 5);
        tick(1); rd(0, v); chk("R6 restart", v, 0);
        rd(1, v); chk("R5 pending restart", {31'd0, v[28]}, 1);
        reg_sel = 0;
        tick(1); rd(0, v); chk("R6 counts again", v, 1);
        // R7 stop
        cur_req = "R7";
        wr(1, mw(2'b10, 0, 0, 28'd10));
        wr(0, 32'd8);
        tick(5); rd(0, v); chk("R7 hold", v, 10);
        rd(1, v); chk("R7 pending", {31'd0, v[28]}, 1);
        // R12 no re-set while held
        cur_req = "R12";
        wr(1, mw(2'b10, 0, 0, 28'd10));
        tick(3); rd(1, v); chk("R12 stays clear", {31'd0, v[28]}, 0);
        rd(0, v); chk("R12 still held", v, 10);
        cur_req = "R7";
        wr(1, mw(2'b11, 0, 0, 28'd10));
        rd(0, v); chk("R7 held at write", v, 10);
        tick(1); rd(0, v); chk("R7 resumes", v, 11);
        rd(1, v); chk("R7 no new pending", {31'd0, v[28]}, 0);
        // R2 field readback, R3 disable mid-run
        cur_req = "R2";
        wr(1, mw(2'b01, 1, 0, 28'hABC_DEF1));
        rd(1, v); chk("R2 readback restart", v, 32'h6ABC_DEF1);
        cur_req = "R3";
        wr(1, mw(2'b00, 0, 0, 28'd0));
        rd(0, a); tick(3); rd(0, v); chk("R3 off freezes", v, a);
        tick(2);
        finish_run();
    end
endmodule